// File: doc/BRIEF.md
# Least-Recently-Picked Thread Issue Selector

This block sits at the front of a single-issue pipelined core that is shared by four hardware threads. In every clock cycle it decides which thread may issue next. The pipeline gives it, for each thread, a ready indication and four blocking conditions: a cache miss in progress, a pending trap, a resource conflict, and an unresolved long-latency operation such as a load, branch, multiply or divide. A thread is eligible only while it is ready and none of its blocking conditions is raised. Among the eligible threads, the one picked longest ago wins. This interleaves the threads at single-cycle granularity.

The decision is registered. The block presents a one-hot thread select and a valid flag one cycle after the inputs it was based on. The recency state is an ordered list of the four thread numbers. When a pick is made, the picked thread moves to the most-recent end of the list. When no thread is eligible, the list is left as it was. These pins are plain control signals: there is no back-pressure, and the consumer takes the select in every cycle where valid is high.

Top module: `mt_thread_picker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pick_valid` is 0 and `pick_sel` is 4'b0000.
- R2: Thread t is eligible only when `thr_ready[t]` is 1 and `miss_block[t]`, `trap_block[t]`, `conflict_block[t]` and `longop_busy[t]` are all 0. A non-eligible thread is never selected.
- R3: When `pick_valid` is 1, `pick_sel` has exactly one bit set, and bit t means thread t. When `pick_valid` is 0, `pick_sel` is 4'b0000.
- R4: When several threads are eligible, the selected thread is the one whose last selection lies furthest in the past.
- R5: If no thread is eligible, `pick_valid` is 0 in the next cycle and the recency order does not change. Later picks then follow the order that held before the idle cycle.
- R6: Inputs sampled at clock edge N decide the outputs seen after edge N. An input change has no effect on the outputs before that edge.
- R7: After reset the recency order, from least to most recent, is thread 0, 1, 2, 3. With all threads eligible, the picks after reset are 0, 1, 2, 3, 0, and so on.
- R8: A selected thread becomes the most recent one. It is not selected in the next cycle if any other thread is eligible then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_ready | input | 4 | Per-thread ready to issue |
| miss_block | input | 4 | Per-thread cache miss in progress |
| trap_block | input | 4 | Per-thread trap being handled |
| conflict_block | input | 4 | Per-thread resource conflict |
| longop_busy | input | 4 | Per-thread long-latency operation outstanding |
| pick_sel | output | 4 | One-hot selected thread (registered) |
| pick_valid | output | 1 | A thread was selected this cycle (registered) |

## Verification
The recency list is the only hidden state. A corrupted list shows up as a wrong pick in the first cycle where two or more threads with swapped positions are eligible together. With all threads eligible, that happens within four cycles. Idle cycles are the risky part: a list that wrongly rotates while nothing is eligible produces a wrong thread on the first pick after the idle gap. For this reason, random stimulus is mixed with directed idle gaps and with masks that change every cycle, and each output is compared against a list kept by the bench.

// File: rtl/mt_pick_pkg.sv
package mt_pick_pkg;
  localparam int NTHR = 4;
  localparam int IDW  = $clog2(NTHR);
  typedef logic [IDW-1:0]  tid_t;
  typedef logic [NTHR-1:0] tmask_t;
endpackage

// File: rtl/mt_thr_avail.sv
module mt_thr_avail
  import mt_pick_pkg::*;
(
  input  tmask_t ready_i,
  input  tmask_t miss_i,
  input  tmask_t trap_i,
  input  tmask_t conflict_i,
  input  tmask_t longop_i,
  output tmask_t elig_o
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign elig_o[t] = ready_i[t] & ~(miss_i[t] | trap_i[t] | conflict_i[t] | longop_i[t]);
  end
endmodule

// File: rtl/mt_lru_order.sv
module mt_lru_order
  import mt_pick_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  tmask_t elig_i,
  output logic   hit_o,
  output tid_t   pick_o
);
  tid_t order_q [NTHR];
  tid_t order_d [NTHR];
  tid_t pos;

  always_comb begin
    hit_o = 1'b0;
    pos   = '0;
    for (int p = NTHR - 1; p >= 0; p--) begin
      if (elig_i[order_q[p]]) begin
        hit_o = 1'b1;
        pos   = tid_t'(p);
      end
    end
    pick_o = order_q[pos];
  end

  always_comb begin
    for (int p = 0; p < NTHR; p++) begin
      int nx;
      nx = (p == NTHR - 1) ? p : p + 1;
      if (!hit_o || tid_t'(p) < pos) order_d[p] = order_q[p];
      else if (p == NTHR - 1)        order_d[p] = order_q[pos];
      else                           order_d[p] = order_q[nx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NTHR; p++) order_q[p] <= tid_t'(p);
    end else begin
      for (int p = 0; p < NTHR; p++) order_q[p] <= order_d[p];
    end
  end

  // The list must stay a permutation of the thread numbers (state integrity for R4).
  tmask_t present;
  always_comb begin
    present = '0;
    for (int p = 0; p < NTHR; p++) present[order_q[p]] = 1'b1;
  end
  p_order_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == NTHR);

  // R5: with nothing eligible the order is frozen.
  p_idle_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_i == '0) |=> (order_q[0] == $past(order_q[0]) && order_q[NTHR-1] == $past(order_q[NTHR-1])));
endmodule

// File: rtl/mt_thread_picker.sv
module mt_thread_picker
  import mt_pick_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] thr_ready,
  input  logic [NTHR-1:0] miss_block,
  input  logic [NTHR-1:0] trap_block,
  input  logic [NTHR-1:0] conflict_block,
  input  logic [NTHR-1:0] longop_busy,
  output logic [NTHR-1:0] pick_sel,
  output logic            pick_valid
);
  tmask_t elig;
  logic   hit;
  tid_t   pick_id;

  mt_thr_avail u_avail (
    .ready_i(thr_ready), .miss_i(miss_block), .trap_i(trap_block),
    .conflict_i(conflict_block), .longop_i(longop_busy), .elig_o(elig)
  );

  mt_lru_order u_lru (
    .clk(clk), .rst_n(rst_n), .elig_i(elig), .hit_o(hit), .pick_o(pick_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_sel   <= '0;
      pick_valid <= 1'b0;
    end else begin
      pick_sel   <= hit ? (tmask_t'(1) << pick_id) : '0;
      pick_valid <= hit;
    end
  end

  p_sel_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid ? $onehot(pick_sel) : (pick_sel == '0));

  p_pick_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ((pick_sel & $past(elig)) != '0));

  p_none_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |=> !pick_valid);

  p_no_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && ((elig & ~pick_sel) != '0)) |=> (pick_sel != $past(pick_sel)));
endmodule

// File: tb/sim_mt_thread_picker.sv
`timescale 1ns/1ps
module sim_mt_thread_picker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rdy = '0, mis = '0, trp = '0, cfl = '0, lop = '0;
  logic [3:0] sel;
  logic       vld;
  int checks = 0, errors = 0;
  int mord [4];
  logic [3:0] exp_sel = '0;
  logic       exp_vld = 1'b0;

  always #4 clk = ~clk;

  mt_thread_picker u0 (
    .clk(clk), .rst_n(rst_n), .thr_ready(rdy), .miss_block(mis), .trap_block(trp),
    .conflict_block(cfl), .longop_busy(lop), .pick_sel(sel), .pick_valid(vld)
  );

  task automatic check(string tag, logic [3:0] es, logic ev);
    checks++;
    if (sel !== es || vld !== ev) begin
      errors++;
      $display("FAIL %s got sel=%b valid=%b expected sel=%b valid=%b", tag, sel, vld, es, ev);
    end
  endtask

  // Model of the recency list: eligible = ready and no block (R2), oldest wins (R4).
  task automatic model(logic [3:0] r, logic [3:0] m, logic [3:0] t, logic [3:0] c, logic [3:0] l);
    logic [3:0] e;
    int p;
    int id;
    e = r & ~m & ~t & ~c & ~l;
    p = -1;
    for (int i = 0; i < 4; i++) if (p < 0 && e[mord[i]]) p = i;
    if (p < 0) begin
      exp_sel = '0; exp_vld = 1'b0;
    end else begin
      id = mord[p];
      for (int i = p; i < 3; i++) mord[i] = mord[i+1];
      mord[3] = id;
      exp_sel = 4'b0001 << id; exp_vld = 1'b1;
    end
  endtask

  // Drive at negedge, check one full cycle later (R6: registered after one edge).
  task automatic step(string tag, logic [3:0] r, logic [3:0] m, logic [3:0] t, logic [3:0] c, logic [3:0] l);
    rdy = r; mis = m; trp = t; cfl = c; lop = l;
    #1;
    check("R6_hold", exp_sel, exp_vld);
    model(r, m, t, c, l);
    @(negedge clk);
    check(tag, exp_sel, exp_vld);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) mord[i] = i;
    repeat (3) @(negedge clk);
    check("R1_in_reset", 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1_after_reset", 4'b0000, 1'b0);
    // R7 reset order: picks 0,1,2,3,0
    for (int k = 0; k < 5; k++) step("R7_R4", 4'hF, 0, 0, 0, 0);
    // R2: each blocking type removes a thread
    step("R2_miss",  4'hF, 4'b0010, 0, 0, 0);
    step("R2_trap",  4'hF, 0, 4'b0100, 0, 0);
    step("R2_conf",  4'hF, 0, 0, 4'b1000, 0);
    step("R2_long",  4'hF, 0, 0, 0, 4'b0001);
    step("R2_notready", 4'b0101, 0, 0, 0, 0);
    // R5: idle gap leaves order unchanged
    step("R5_idle", 4'h0, 0, 0, 0, 0);
    step("R5_idle", 4'hF, 4'hF, 0, 0, 0);
    step("R5_resume", 4'hF, 0, 0, 0, 0);
    step("R5_resume", 4'hF, 0, 0, 0, 0);
    // R8: single thread repeats, then yields when another appears
    step("R8_single", 4'b0100, 0, 0, 0, 0);
    step("R8_single", 4'b0100, 0, 0, 0, 0);
    step("R8_yield", 4'b0110, 0, 0, 0, 0);
    step("R8_yield", 4'b0110, 0, 0, 0, 0);
    // random mix, blocks kept sparse
    for (int k = 0; k < 400; k++) begin
      logic [3:0] r, m, t, c, l;
      r = 4'($urandom);
      m = 4'($urandom) & 4'($urandom);
      t = 4'($urandom) & 4'($urandom) & 4'($urandom);
      c = 4'($urandom) & 4'($urandom) & 4'($urandom);
      l = 4'($urandom) & 4'($urandom);
      step("R3_R4_rand", r, m, t, c, l);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule